// File: doc/BRIEF.md
# Synchronized Rising-Edge Pulse Generator

This block takes a slow level that arrives with no timing relation to the clock, such as a push button or a toggle switch, and emits a pulse exactly one clock period wide each time that level goes from low to high. The raw input first passes through a short chain of flip-flops. The first flop in the chain may go metastable, and the later stages give it time to settle. Only the last stage of the chain feeds the edge logic, so every consumer inside the block sees the same cycle for a transition.

A compile-time mode picks the style of the edge logic. The registered style is a three-state machine whose output is decoded from its state alone. The immediate style keeps one flop that holds the previous synchronized level, and its output is a gate on that flop and the current synchronized level. For the same input edge, the immediate style responds one cycle sooner. A second parameter sets the synchronizer depth to one or two stages.

Top module: `level_pulser`

## Requirements
- R1: While `rstN` is low, `pulse` is 0 and all flops are cleared. If `rawLevel` is already high when reset is released, exactly one pulse follows, with the normal latency.
- R2: `rawLevel` is sampled by a single flop. The synchronized level equals the value `rawLevel` had `SYNC_DEPTH` rising clock edges earlier. `SYNC_DEPTH` is 1 or 2, and the default is 2.
- R3: With `MODE = PM_MEALY` (encoding 1), a rise of `rawLevel` driven between two edges gives `pulse` high in the cycle that follows the `SYNC_DEPTH`-th rising edge after the change.
- R4: With `MODE = PM_MOORE` (encoding 0, the default), the same rise gives `pulse` high one cycle later than in R3, after the (`SYNC_DEPTH`+1)-th edge. The internal state codes are 00 for waiting for a rise, 01 for an edge seen, and 11 for waiting for a fall. The unused code 10 returns to 00.
- R5: `pulse` never stays high for two consecutive cycles.
- R6: No further pulse occurs while `rawLevel` stays high, however long it stays high.
- R7: Every low-to-high transition of `rawLevel` gives exactly one pulse, even when the high and low phases each last only one clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rawLevel | input | 1 | Unsynchronized level input |
| pulse | output | 1 | One-cycle pulse on each rise of the level |

## Verification
A wrong state in the registered machine shows up as one of three faults at `pulse`. It can be a missing pulse, a doubled pulse, or a pulse shifted by one cycle. Any of these is visible within two cycles of the synchronized edge that follows the fault. A fault in a synchronizer stage shows up at once as a pulse whose latency differs from the depth-derived value. The bench compares `pulse` in every cycle, for all four combinations of mode and depth, against a model built from the sampled input history. A fault is therefore caught in the first cycle where it becomes observable.

// File: rtl/lp_pkg.sv
package lp_pkg;

  // Output style of the edge logic.
  typedef enum logic {
    PM_MOORE = 1'b0,
    PM_MEALY = 1'b1
  } pulseMode_e;

  // State codes of the registered machine. Code 2'b10 is not used.
  typedef enum logic [1:0] {
    ST_WAIT_RISE = 2'b00,
    ST_EDGE      = 2'b01,
    ST_WAIT_FALL = 2'b11
  } edgeState_e;

  // Strobes passed from the datapath to the control.
  typedef struct packed {
    logic level;
  } syncStrobe_t;

endpackage

// File: rtl/lp_sync_chain.sv
module lp_sync_chain #(
  parameter int DEPTH = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rawLevel,
  output lp_pkg::syncStrobe_t stb
);

  localparam int LAST = DEPTH - 1;

  logic [LAST:0] stage;

  // rawLevel reaches stage[0] and nothing else.
  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage <= '0;
        else       stage <= rawLevel;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage <= '0;
        else       stage <= {stage[LAST-1:0], rawLevel};
      end
    end
  endgenerate

  assign stb.level = stage[LAST];

endmodule

// File: rtl/lp_edge_ctrl.sv
module lp_edge_ctrl #(
  parameter lp_pkg::pulseMode_e MODE = lp_pkg::PM_MOORE
) (
  input  logic                clk,
  input  logic                rstN,
  input  lp_pkg::syncStrobe_t stb,
  output logic                pulse
);

  import lp_pkg::*;

  generate
    if (MODE == PM_MEALY) begin : g_mealy
      logic prevLevel;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) prevLevel <= 1'b0;
        else       prevLevel <= stb.level;
      end

      assign pulse = stb.level & ~prevLevel;
    end else begin : g_moore
      edgeState_e curState, nxtState;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) curState <= ST_WAIT_RISE;
        else       curState <= nxtState;
      end

      always_comb begin
        nxtState = ST_WAIT_RISE;
        if (stb.level) begin
          case (curState)
            ST_WAIT_RISE: nxtState = ST_EDGE;
            ST_EDGE:      nxtState = ST_WAIT_FALL;
            ST_WAIT_FALL: nxtState = ST_WAIT_FALL;
            default:      nxtState = ST_WAIT_RISE;
          endcase
        end
      end

      assign pulse = (curState == ST_EDGE);
    end
  endgenerate

endmodule

// File: rtl/level_pulser.sv
module level_pulser #(
  parameter int                 SYNC_DEPTH = 2,
  parameter lp_pkg::pulseMode_e MODE       = lp_pkg::PM_MOORE
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawLevel,
  output logic pulse
);

  lp_pkg::syncStrobe_t syncStb;

  lp_sync_chain #(.DEPTH(SYNC_DEPTH)) u_sync (
    .clk      (clk),
    .rstN     (rstN),
    .rawLevel (rawLevel),
    .stb      (syncStb)
  );

  lp_edge_ctrl #(.MODE(MODE)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (syncStb),
    .pulse (pulse)
  );

endmodule

// File: rtl/lp_checker.sv
module lp_checker #(
  parameter int                 SYNC_DEPTH = 2,
  parameter lp_pkg::pulseMode_e MODE       = lp_pkg::PM_MOORE
) (
  input logic                clk,
  input logic                rstN,
  input logic                rawLevel,
  input lp_pkg::syncStrobe_t syncStb,
  input logic                pulse
);

  logic       syncLevel;
  logic [1:0] upCnt;

  assign syncLevel = syncStb.level;

  // Counts edges since reset release, saturating at 3.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              upCnt <= 2'd0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
  end

  // R1
  a_r1_quiet_in_reset: assert property (@(posedge clk) !rstN |-> !pulse);

  // R5
  a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    pulse |=> !pulse);

  generate
    if (SYNC_DEPTH == 1) begin : g_d1
      // R2
      a_r2_sync_delay: assert property (@(posedge clk) disable iff (!rstN)
        (upCnt >= 2'd1) |-> (syncLevel == $past(rawLevel)));
    end else if (SYNC_DEPTH == 2) begin : g_d2
      // R2
      a_r2_sync_delay: assert property (@(posedge clk) disable iff (!rstN)
        (upCnt >= 2'd2) |-> (syncLevel == $past(rawLevel, 2)));
    end

    if (MODE == lp_pkg::PM_MEALY) begin : g_mealy
      // R3
      a_r3_rise_now: assert property (@(posedge clk) disable iff (!rstN)
        (upCnt >= 2'd1 && syncLevel && !$past(syncLevel)) |-> pulse);
      // R6
      a_r6_hold_quiet: assert property (@(posedge clk) disable iff (!rstN)
        (upCnt >= 2'd1 && syncLevel && $past(syncLevel)) |-> !pulse);
    end else begin : g_moore
      // R4
      a_r4_rise_late: assert property (@(posedge clk) disable iff (!rstN)
        (upCnt >= 2'd2 && $past(syncLevel) && !$past(syncLevel, 2)) |-> pulse);
      // R6
      a_r6_hold_quiet: assert property (@(posedge clk) disable iff (!rstN)
        (upCnt >= 2'd2 && $past(syncLevel) && $past(syncLevel, 2)) |-> !pulse);
    end
  endgenerate

endmodule

bind level_pulser lp_checker #(.SYNC_DEPTH(SYNC_DEPTH), .MODE(MODE)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .rawLevel (rawLevel),
  .syncStb  (syncStb),
  .pulse    (pulse)
);

// File: tb/test_level_pulser.sv
`timescale 1ns/1ps
module test_level_pulser;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rawLevel = 1'b0;
  logic [3:0] dutPulse;
  logic [3:0] hist = '0;   // hist[0] = rawLevel at the latest edge
  int   total = 0;
  int   bad = 0;
  int   rises [4];
  int   pulses [4];
  bit   done = 0;

  always #2 clk = ~clk;   // 250 MHz

  // index 0: Moore depth 2 (defaults), 1: Mealy depth 2, 2: Moore depth 1, 3: Mealy depth 1
  level_pulser i_level_pulser (.clk(clk), .rstN(rstN), .rawLevel(rawLevel), .pulse(dutPulse[0]));
  level_pulser #(.SYNC_DEPTH(2), .MODE(lp_pkg::PM_MEALY)) i_level_pulser_me2 (
    .clk(clk), .rstN(rstN), .rawLevel(rawLevel), .pulse(dutPulse[1]));
  level_pulser #(.SYNC_DEPTH(1), .MODE(lp_pkg::PM_MOORE)) i_level_pulser_mo1 (
    .clk(clk), .rstN(rstN), .rawLevel(rawLevel), .pulse(dutPulse[2]));
  level_pulser #(.SYNC_DEPTH(1), .MODE(lp_pkg::PM_MEALY)) i_level_pulser_me1 (
    .clk(clk), .rstN(rstN), .rawLevel(rawLevel), .pulse(dutPulse[3]));

  // Expected pulse from the requirements: Mealy latency = depth, Moore = depth + 1.
  function automatic logic expPulse(int idx);
    int d = (idx < 2) ? 2 : 1;
    bit mealy = (idx % 2) == 1;
    if (mealy) return hist[d-1] & ~hist[d];
    else       return hist[d]   & ~hist[d+1];
  endfunction

  task automatic check(string tag, logic act, logic exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // One clock: the edge samples rawLevel, then compare all four outputs.
  task automatic step(string tag);
    @(posedge clk);
    if (rstN) hist = {hist[2:0], rawLevel};
    else      hist = '0;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      check(tag, dutPulse[i], expPulse(i), $sformatf("pulse dut%0d", i));
      if (dutPulse[i] === 1'b1) pulses[i]++;
    end
  endtask

  task automatic drive(logic v, int n, string tag);
    rawLevel = v;
    for (int k = 0; k < n; k++) step(tag);
  endtask

  task automatic clearCounts();
    for (int i = 0; i < 4; i++) begin rises[i] = 0; pulses[i] = 0; end
  endtask

  // R1: quiet during reset with the input high, then one pulse after release.
  task automatic t_reset_high();
    rstN = 1'b0;
    rawLevel = 1'b1;
    for (int k = 0; k < 3; k++) begin
      step("R1");
    end
    clearCounts();
    rstN = 1'b1;
    drive(1'b1, 8, "R1");
    for (int i = 0; i < 4; i++) check("R1", 1'(pulses[i]), 1'b1, $sformatf("pulse count dut%0d", i));
  endtask

  // R6, R5, R3, R4: one long high phase gives a single pulse.
  task automatic t_long_high();
    drive(1'b0, 5, "R6");
    clearCounts();
    drive(1'b1, 40, "R6");
    for (int i = 0; i < 4; i++) check("R6", 1'(pulses[i]), 1'b1, $sformatf("pulse count dut%0d", i));
    drive(1'b0, 5, "R5");
  endtask

  // R7: one-cycle high and low phases.
  task automatic t_fast_toggle();
    drive(1'b0, 4, "R7");
    clearCounts();
    for (int k = 0; k < 10; k++) begin
      drive(1'b1, 1, "R7");
      drive(1'b0, 1, "R7");
    end
    drive(1'b0, 4, "R7");
    for (int i = 0; i < 4; i++) check("R7", 1'(pulses[i] == 10), 1'b1,
                                      $sformatf("ten pulses dut%0d", i));
  endtask

  // R2, R3, R4: random phase lengths, every cycle compared to the model.
  task automatic t_random();
    int nRise = 0;
    clearCounts();
    for (int k = 0; k < 60; k++) begin
      drive(1'b1, 1 + ($urandom % 20), "R2");
      nRise++;
      drive(1'b0, 1 + ($urandom % 20), "R3");
    end
    drive(1'b0, 4, "R4");
    for (int i = 0; i < 4; i++) check("R7", 1'(pulses[i] == nRise), 1'b1,
                                      $sformatf("pulse per rise dut%0d", i));
  endtask

  initial begin
    @(negedge clk);
    for (int i = 0; i < 4; i++) check("R1", dutPulse[i], 1'b0, "pulse in reset");
    t_reset_high();
    t_long_high();
    t_fast_toggle();
    t_random();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule